// File: doc/BRIEF.md
# Frame-Sync-Timed Reset Controller

This block drives the internal active-low reset line of a line-card signal processor. A reset request comes from either of two places: an external hardware reset pin, which is synchronized into the clock domain, or a software reset bit held in a control register in the same clock domain. While a request is present, the internal line is low. Once the request is gone, the block counts rising edges of the incoming frame sync. It raises the line only after a fixed number of edges, so the hold time follows the frame rate and not the clock rate. With 80 frames this gives at least 18 ms.

While the line is low, the block asserts hold outputs for the DSP core and for the capture latches of the external interfaces. In the cycle the line goes high, it emits a one-cycle completion pulse. This pulse lets the DSP core start fetching from ROM address 0. A separate path forwards a software reset request to the companion codec devices. That path stays blocked for a guard window of clock cycles after power-on, because their clock may not yet be valid during that window.

Top module: `fsync_rst_ctrl`

## Requirements
- R1: Directly after power-on reset, `int_rst_n` is 0, `dsp_hold` and `latch_hold` are 1, and `rst_done` and `codec_rst_o` are 0.
- R2: While `hw_rst_n` is 0, `int_rst_n` is 0 no later than the third rising clock edge after the pin falls, and it stays 0.
- R3: `sw_rst_bit` at 1 on a clock edge drives `int_rst_n` to 0 at the next clock edge.
- R4: With no request active, `int_rst_n` rises after exactly `FRAME_COUNT` (default 80) rising edges of `fsync` have been counted, and it does not rise after one fewer.
- R5: Frame sync edges that arrive while a request is active are not counted. A request that arrives while counting is under way restarts the count from zero.
- R6: `rst_done` is 1 for exactly one cycle for each release, and only in the cycle in which `int_rst_n` changes from 0 to 1.
- R7: `dsp_hold` and `latch_hold` are 1 exactly while `int_rst_n` is 0.
- R8: A frame sync held high for many cycles counts as one edge.
- R9: `codec_rst_o` stays 0 for `GUARD_CYCLES` cycles after power-on reset is released, whatever `codec_rst_req` does. After that window it follows `codec_rst_req` with one cycle of latency.
- R10: While `int_rst_n` is 1 and no request is present, `fsync` edges have no effect: `int_rst_n` stays 1 and `rst_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously, released synchronously inside |
| hw_rst_n | input | 1 | External hardware reset pin, active low, asynchronous |
| sw_rst_bit | input | 1 | Software reset bit from control register, active high, synchronous |
| fsync | input | 1 | Frame sync pulse, asynchronous |
| codec_rst_req | input | 1 | Software reset request for the companion codecs |
| int_rst_n | output | 1 | Internal reset line, active low |
| dsp_hold | output | 1 | Holds the DSP core in reset |
| latch_hold | output | 1 | Blocks data capture on external interfaces |
| rst_done | output | 1 | One-cycle pulse when the internal reset is released |
| codec_rst_o | output | 1 | Gated software reset to the companion codecs |

## Verification
The assertions assume three things about the inputs. `sw_rst_bit` and `codec_rst_req` are synchronous to `clk`. Each `fsync` level lasts for more than two clock cycles, so that the two-flop synchronizer sees every edge. `GUARD_CYCLES` is at least 1. The stimulus meets these assumptions. It changes the synchronous inputs only on falling clock edges, and it drives frame pulses four cycles high and four cycles low. It reduces the guard window to a few hundred cycles so that both sides of the window are reached.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } fsr_state_e;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      always_comb stg_d = d;
    end else begin : g_next
      always_comb stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/fsr_frame_counter.sv
module fsr_frame_counter #(
  parameter int FRAME_COUNT = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_s,
  input  logic clear,
  input  logic enable,
  output logic release_o
);
  localparam int CW = $clog2(FRAME_COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_COUNT - 1);

  logic          prev_q;
  logic          edge_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign edge_s = fsync_s & ~prev_q;

  always_comb begin
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    release_o = 1'b0;
    if (clear) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (enable && edge_s) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d     = '0;
        release_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= fsync_s;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> $stable(cnt_q));
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0) && !release_o);
endmodule

// File: rtl/fsr_guard_timer.sv
module fsr_guard_timer #(
  parameter int GUARD_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ok
);
  localparam int GW = $clog2(GUARD_CYCLES + 1);
  localparam logic [GW-1:0] GLAST = GW'(GUARD_CYCLES - 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;
  logic          tick_en;

  assign tick_en = ~ok_q;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    ok_d  = (cnt_q == GLAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign ok = ok_q;

  a_r9_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |=> ok_q);
endmodule

// File: rtl/fsync_rst_ctrl.sv
module fsync_rst_ctrl #(
  parameter int FRAME_COUNT  = 80,
  parameter int GUARD_CYCLES = 2_500_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic hw_rst_n,
  input  logic sw_rst_bit,
  input  logic fsync,
  input  logic codec_rst_req,
  output logic int_rst_n,
  output logic dsp_hold,
  output logic latch_hold,
  output logic rst_done,
  output logic codec_rst_o
);
  import fsr_pkg::*;

  logic       sys_rst_n;
  logic [1:0] async_in, async_s;
  logic       hw_req, rst_req;
  logic       release_s;
  logic       guard_ok;

  fsr_state_e st_q, st_d;
  logic       done_q, done_d;
  logic       codec_q, codec_d;

  fsr_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .rst_n(por_n), .d(1'b1), .q(sys_rst_n)
  );

  assign async_in = {hw_rst_n, fsync};
  fsr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_in_sync (
    .clk(clk), .rst_n(sys_rst_n), .d(async_in), .q(async_s)
  );

  assign hw_req  = ~async_s[1];
  assign rst_req = hw_req | sw_rst_bit;

  fsr_frame_counter #(.FRAME_COUNT(FRAME_COUNT)) u_cnt (
    .clk(clk), .rst_n(sys_rst_n), .fsync_s(async_s[0]),
    .clear(rst_req), .enable(st_q == ST_HOLD), .release_o(release_s)
  );

  fsr_guard_timer #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk(clk), .rst_n(sys_rst_n), .ok(guard_ok)
  );

  always_comb begin
    st_d = st_q;
    if (rst_req)        st_d = ST_HOLD;
    else if (release_s) st_d = ST_RUN;
    done_d  = release_s & ~rst_req;
    codec_d = codec_rst_req & guard_ok;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      st_q    <= ST_HOLD;
      done_q  <= 1'b0;
      codec_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      codec_q <= codec_d;
    end
  end

  assign int_rst_n   = (st_q == ST_RUN);
  assign dsp_hold    = ~int_rst_n;
  assign latch_hold  = ~int_rst_n;
  assign rst_done    = done_q;
  assign codec_rst_o = codec_q;

  a_r3_sw_forces_low: assert property (@(posedge clk) disable iff (!sys_rst_n)
    sw_rst_bit |=> !int_rst_n);
  a_r2_hw_forces_low: assert property (@(posedge clk) disable iff (!sys_rst_n)
    hw_req |=> !int_rst_n);
  a_r6_done_on_rise: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_done |-> int_rst_n && !$past(int_rst_n));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rst_done |=> !rst_done);
  a_r9_codec_guard: assert property (@(posedge clk) disable iff (!sys_rst_n)
    codec_rst_o |-> guard_ok);
  a_r7_holds: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $onehot0({int_rst_n, latch_hold}) && (dsp_hold == latch_hold));
endmodule

// File: tb/fsync_rst_ctrl_bench.sv
module fsync_rst_ctrl_bench;
  localparam int FC = 80;
  localparam int GC = 300;

  logic clk = 1'b0;
  logic por_n, hw_rst_n, sw_rst_bit, fsync, codec_rst_req;
  logic int_rst_n, dsp_hold, latch_hold, rst_done, codec_rst_o;

  int n_chk = 0, n_fail = 0, n_done = 0;
  logic prev_int = 1'b0;
  bit   ended = 0;

  always #2 clk = ~clk;

  fsync_rst_ctrl #(.FRAME_COUNT(FC), .GUARD_CYCLES(GC)) u_fsync_rst_ctrl (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .sw_rst_bit(sw_rst_bit),
    .fsync(fsync), .codec_rst_req(codec_rst_req), .int_rst_n(int_rst_n),
    .dsp_hold(dsp_hold), .latch_hold(latch_hold), .rst_done(rst_done),
    .codec_rst_o(codec_rst_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R6 monitor: every done pulse coincides with a 0->1 change of the line
  always @(negedge clk) begin
    if (por_n === 1'b1 && rst_done === 1'b1) begin
      n_done++;
      check(int_rst_n && !prev_int, "R6 done on rise", int'(prev_int), 0);
    end
    prev_int <= int_rst_n;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      fsync = 1'b1; cyc(4);
      fsync = 1'b0; cyc(4);
    end
  endtask

  task automatic t_por;
    check(int_rst_n == 0, "R1 int_rst_n", int'(int_rst_n), 0);
    check(dsp_hold == 1 && latch_hold == 1, "R1 holds", int'({dsp_hold, latch_hold}), 3);
    check(rst_done == 0, "R1 rst_done", int'(rst_done), 0);
    check(codec_rst_o == 0, "R1 codec", int'(codec_rst_o), 0);
  endtask

  task automatic t_guard;
    codec_rst_req = 1'b1;
    cyc(250);
    check(codec_rst_o == 0, "R9 blocked in window", int'(codec_rst_o), 0);
    cyc(70);
    check(codec_rst_o == 1, "R9 forwarded after window", int'(codec_rst_o), 1);
    codec_rst_req = 1'b0;
    cyc(2);
    check(codec_rst_o == 0, "R9 follows request", int'(codec_rst_o), 0);
  endtask

  task automatic t_release;
    int d0 = n_done;
    pulses(FC - 1);
    check(int_rst_n == 0, "R4 held after N-1", int'(int_rst_n), 0);
    pulses(1);
    check(int_rst_n == 1, "R4 released after N", int'(int_rst_n), 1);
    check(dsp_hold == 0 && latch_hold == 0, "R7 holds off", int'({dsp_hold, latch_hold}), 0);
    check(n_done - d0 == 1, "R6 one pulse", n_done - d0, 1);
  endtask

  task automatic t_sw;
    sw_rst_bit = 1'b1; cyc(1);
    sw_rst_bit = 1'b0;
    check(int_rst_n == 0, "R3 sw reset", int'(int_rst_n), 0);
    check(dsp_hold == 1 && latch_hold == 1, "R7 holds on", int'({dsp_hold, latch_hold}), 3);
  endtask

  task automatic t_level;
    t_sw();
    fsync = 1'b1; cyc(60);
    fsync = 1'b0; cyc(4);
    pulses(FC - 2);
    check(int_rst_n == 0, "R8 level counts once", int'(int_rst_n), 0);
    pulses(1);
    check(int_rst_n == 1, "R8 release", int'(int_rst_n), 1);
  endtask

  task automatic t_ignore;
    sw_rst_bit = 1'b1;
    pulses(10);
    sw_rst_bit = 1'b0; cyc(2);
    pulses(FC - 1);
    check(int_rst_n == 0, "R5 edges during request ignored", int'(int_rst_n), 0);
    pulses(1);
    check(int_rst_n == 1, "R5 release", int'(int_rst_n), 1);
  endtask

  task automatic t_restart;
    t_sw();
    pulses(50);
    sw_rst_bit = 1'b1; cyc(1);
    sw_rst_bit = 1'b0;
    pulses(FC - 1);
    check(int_rst_n == 0, "R5 count restarted", int'(int_rst_n), 0);
    pulses(1);
    check(int_rst_n == 1, "R5 release after restart", int'(int_rst_n), 1);
  endtask

  task automatic t_hw;
    hw_rst_n = 1'b0; cyc(3);
    check(int_rst_n == 0, "R2 hw reset", int'(int_rst_n), 0);
    pulses(3);
    hw_rst_n = 1'b1; cyc(3);
    check(int_rst_n == 0, "R2 still held", int'(int_rst_n), 0);
    pulses(FC);
    check(int_rst_n == 1, "R2 release", int'(int_rst_n), 1);
  endtask

  task automatic t_run;
    int d0 = n_done;
    pulses(100);
    check(int_rst_n == 1, "R10 stays released", int'(int_rst_n), 1);
    check(n_done == d0, "R10 no done pulse", n_done - d0, 0);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    por_n = 1'b0; hw_rst_n = 1'b1; sw_rst_bit = 1'b0;
    fsync = 1'b0; codec_rst_req = 1'b0;
    cyc(4);
    por_n = 1'b1;
    cyc(1);
    t_por();
    t_guard();
    t_release();
    t_run();
    t_level();
    t_sw();
    t_ignore();
    t_restart();
    t_hw();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end
endmodule